// File: doc/BRIEF.md
# Data Link Receive Status and Interrupt Registers

This block holds the status and interrupt registers for the receive side of a data link channel that carries HDLC-framed messages. The deframer reports three kinds of event as single-cycle pulses: a message of the multi-octet type, marked by idle flags; an abort sequence; and a frame check failure. A frame check failure is also reported when an idle flag arrives that is not aligned to an octet boundary. Each event sets a sticky bit in a status register.

Each status bit has its own interrupt enable. The enabled bits are ORed together and then gated by a block-level enable, which gives one level-sensitive interrupt line. A small register bus reads and writes the registers. A control bit chooses how software clears status, and this choice can change at run time. In read-clear mode, reading the status register clears it. In write-one-clear mode, software writes ones to the bits it wants cleared.

Top module: `dls_irq_top`

## Requirements
- R1: After reset, the status register, the enable register and the control register are all zero, and irq_o and rdata_o are both 0.
- R2: A pulse on evt_i[k] sets status bit k. Bit 0 means a multi-octet message (idle flags seen), bit 1 means an abort was received, and bit 2 means a frame check error.
- R3: A pulse on idle_misalign_i sets status bit 2.
- R4: A status bit stays set across later cycles until a clear that this requirement set allows removes it.
- R5: Control bit 1 set to 1 selects read-clear mode. A read at address 0 returns the status value on rdata_o one cycle after rd_en_i, and the same clock edge clears every status bit.
- R6: Control bit 1 set to 0 selects write-one-clear mode. A write at address 0 clears each status bit whose wdata_i bit is 1 and leaves each bit whose wdata_i bit is 0 unchanged.
- R7: In read-clear mode, writes to address 0 have no effect. In write-one-clear mode, reads of address 0 do not clear status.
- R8: If an event arrives on the same cycle as a clearing read or write, the status bit it sets is still 1 afterwards.
- R9: irq_o equals control bit 0 (block enable) ANDed with the OR over all k of status[k] AND enable[k]. It is active high and follows the registers without delay.
- R10: Address 1 is the read/write enable register with one bit per status bit. Address 2 is the control register, where bit 0 is the block enable and bit 1 is the clear mode. Control bits above bit 1 read as 0. rdata_o is 0 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_EVT | Event pulses from the receiver: bit 0 multi-octet message, bit 1 abort, bit 2 frame check error |
| idle_misalign_i | input | 1 | Pulse when an idle flag arrives off an octet boundary |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address: 0 status, 1 enable, 2 control |
| wdata_i | input | N_EVT | Write data |
| rdata_o | output | N_EVT | Read data, registered, valid the cycle after rd_en_i |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The assertions assume that the event inputs are clean single-cycle pulses, that the bus strobes are never unknown after reset, and that a status bit changes only through an event or a clear. The stimulus drives every input on the falling edge and holds each event and strobe for exactly one cycle. It uses only addresses 0 to 2. Writes and reads overlap events only in the collision cases, where that overlap is the point of the test.

// File: rtl/dls_pkg.sv
package dls_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STAT = 2'd0,
    ADDR_IEN  = 2'd1,
    ADDR_CTRL = 2'd2
  } dls_addr_e;

  localparam int unsigned EVT_MOS   = 0;
  localparam int unsigned EVT_ABORT = 1;
  localparam int unsigned EVT_FCS   = 2;

  localparam int unsigned CTRL_BLK_EN = 0;
  localparam int unsigned CTRL_COR    = 1;
  localparam int unsigned CTRL_W      = 2;
endpackage

// File: rtl/dls_ctrl_regs.sv
module dls_ctrl_regs
  import dls_pkg::*;
#(
  parameter int unsigned N_EVT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_EVT-1:0] wdata_i,
  output logic [N_EVT-1:0] ien_o,
  output logic             blk_en_o,
  output logic             cor_mode_o
);
  logic [N_EVT-1:0]  ien_q;
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_IEN)  ien_q  <= wdata_i;
      if (addr_i == ADDR_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
    end
  end

  assign ien_o      = ien_q;
  assign blk_en_o   = ctrl_q[CTRL_BLK_EN];
  assign cor_mode_o = ctrl_q[CTRL_COR];

  AST_IEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_IEN) |=> $stable(ien_o)); // R10
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_CTRL) |=> $stable(cor_mode_o) && $stable(blk_en_o)); // R10
endmodule

// File: rtl/dls_stat_bit.sv
module dls_stat_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic stat_o
);
  logic stat_q;

  // a set wins over a clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= 1'b0;
    else if (set_i) stat_q <= 1'b1;
    else if (clr_i) stat_q <= 1'b0;
  end

  assign stat_o = stat_q;

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> stat_o); // R8
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && !clr_i |=> $stable(stat_o)); // R4
  AST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !stat_o); // R5
endmodule

// File: rtl/dls_irq_merge.sv
module dls_irq_merge #(
  parameter int unsigned N_EVT = 3
) (
  input  logic [N_EVT-1:0] stat_i,
  input  logic [N_EVT-1:0] ien_i,
  input  logic             blk_en_i,
  output logic             irq_o
);
  logic [N_EVT-1:0] hit;

  always_comb begin
    for (int k = 0; k < N_EVT; k++) hit[k] = stat_i[k] & ien_i[k];
  end

  assign irq_o = blk_en_i & (|hit);

  always_comb begin
    if (!blk_en_i) AST_BLK_GATE: assert (!irq_o); // R9
    if ((stat_i & ien_i) == '0) AST_NO_SRC: assert (!irq_o); // R9
  end
endmodule

// File: rtl/dls_irq_top.sv
module dls_irq_top
  import dls_pkg::*;
#(
  parameter int unsigned N_EVT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              idle_misalign_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_EVT-1:0]  wdata_i,
  output logic [N_EVT-1:0]  rdata_o,
  output logic              irq_o
);
  logic [N_EVT-1:0] ien, stat, set_vec, clr_vec, rdata_d;
  logic             blk_en, cor_mode, rd_stat, wr_stat;

  dls_ctrl_regs #(.N_EVT(N_EVT)) i_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .ien_o(ien), .blk_en_o(blk_en), .cor_mode_o(cor_mode)
  );

  assign rd_stat = rd_en_i && addr_i == ADDR_STAT;
  assign wr_stat = wr_en_i && addr_i == ADDR_STAT;

  always_comb begin
    set_vec = evt_i;
    set_vec[EVT_FCS] = evt_i[EVT_FCS] | idle_misalign_i;
  end

  for (genvar k = 0; k < N_EVT; k++) begin : g_stat
    assign clr_vec[k] = cor_mode ? rd_stat : (wr_stat & wdata_i[k]);
    dls_stat_bit i_bit (
      .clk_i, .rst_ni, .set_i(set_vec[k]), .clr_i(clr_vec[k]), .stat_o(stat[k])
    );
  end

  always_comb begin
    rdata_d = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        ADDR_STAT: rdata_d = stat;
        ADDR_IEN:  rdata_d = ien;
        ADDR_CTRL: begin
          rdata_d[CTRL_BLK_EN] = blk_en;
          rdata_d[CTRL_COR]    = cor_mode;
        end
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rdata_d;
  end

  dls_irq_merge #(.N_EVT(N_EVT)) i_merge (
    .stat_i(stat), .ien_i(ien), .blk_en_i(blk_en), .irq_o
  );

  AST_MISALIGN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_misalign_i |=> stat[EVT_FCS]); // R3
  AST_COR_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cor_mode && !rd_stat && set_vec == '0 |=> $stable(stat)); // R7
  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rdata_o == '0); // R10
  AST_RD_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |=> rdata_o == $past(stat)); // R5
endmodule

// File: tb/test_dls_irq_top.sv
module test_dls_irq_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_EVT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_EVT-1:0] evt = '0, wdata = '0, rdata;
  logic misal = 1'b0, wr_en = 1'b0, rd_en = 1'b0, irq;
  logic [1:0] addr = '0;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dls_irq_top #(.N_EVT(N_EVT)) i_dls_irq_top (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .idle_misalign_i(misal),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N_EVT-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N_EVT-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [N_EVT-1:0] p);
    @(negedge clk); evt = p;
    @(negedge clk); evt = '0;
  endtask

  task automatic clear_all();
    logic [N_EVT-1:0] c;
    rd(2'd2, c);
    wr(2'd2, c & 3'b001);
    wr(2'd0, 3'b111);
    wr(2'd2, c);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog got=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [N_EVT-1:0] d;
    repeat (3) @(negedge clk);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rdata", int'(rdata), 0);
    rst_n = 1'b1;
    rd(2'd0, d); chk("R1 status", int'(d), 0);
    rd(2'd1, d); chk("R1 enable", int'(d), 0);
    rd(2'd2, d); chk("R1 control", int'(d), 0);
    @(negedge clk); chk("R10 idle rdata", int'(rdata), 0);

    wr(2'd1, 3'b101); rd(2'd1, d); chk("R10 enable readback", int'(d), 5);
    wr(2'd2, 3'b111); rd(2'd2, d); chk("R10 control readback", int'(d), 3);

    // sweep: mode x block enable x enables x event pattern
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 2; b++)
        for (int e = 0; e < 8; e++)
          for (int p = 0; p < 8; p++) begin
            wr(2'd2, 3'(b | (m << 1)));
            wr(2'd1, 3'(e));
            clear_all();
            pulse(3'(p));
            chk("R2 R9 irq", int'(irq), (b != 0 && (p & e) != 0) ? 1 : 0);
            repeat (2) @(negedge clk);
            chk("R4 irq held", int'(irq), (b != 0 && (p & e) != 0) ? 1 : 0);
            rd(2'd0, d); chk("R2 status", int'(d), p);
            rd(2'd0, d);
            if (m == 1) chk("R5 cleared by read", int'(d), 0);
            else        chk("R7 read keeps status", int'(d), p);
            if (m == 1) chk("R5 R9 irq after clear", int'(irq), 0);
          end

    // write-one-clear masks
    wr(2'd2, 3'b000);
    for (int w = 0; w < 8; w++) begin
      clear_all();
      pulse(3'b111);
      wr(2'd0, 3'(w));
      rd(2'd0, d); chk("R6 w1c mask", int'(d), 7 & ~w);
    end

    // writes ignored in read-clear mode
    wr(2'd2, 3'b010);
    clear_all();
    pulse(3'b110);
    wr(2'd0, 3'b111);
    wr(2'd2, 3'b000);
    rd(2'd0, d); chk("R7 write ignored in read-clear", int'(d), 6);

    // misaligned idle
    clear_all();
    @(negedge clk); misal = 1'b1;
    @(negedge clk); misal = 1'b0;
    rd(2'd0, d); chk("R3 misalign sets bit2", int'(d), 4);

    // collision, write-one-clear mode
    wr(2'd2, 3'b000);
    clear_all();
    pulse(3'b011);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 3'b111; evt = 3'b010;
    @(negedge clk); wr_en = 1'b0; wdata = '0; evt = '0;
    rd(2'd0, d); chk("R8 w1c collision", int'(d), 2);

    // collision, read-clear mode
    wr(2'd2, 3'b010);
    clear_all();
    pulse(3'b011);
    @(negedge clk); rd_en = 1'b1; addr = 2'd0; evt = 3'b001;
    @(negedge clk); rd_en = 1'b0; evt = '0;
    chk("R5 read value", int'(rdata), 3);
    rd(2'd0, d); chk("R8 read-clear collision", int'(d), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule